// File: doc/BRIEF.md
# Timer Run and External Interrupt Flag Register

This block is an 8-bit control and status byte. It holds run enables for two timers and pending flags for the overflow of those timers. It also holds pending flags for two active-low external interrupt pins, each with its own sensing-mode bit. Software reads and writes the byte through a simple strobe port. The timers report overflow with one-cycle pulses. An interrupt controller takes the pending flags and returns an acknowledge pulse when it vectors to the matching routine.

Each pending flag is a two-state machine with states `FL_IDLE` and `FL_PEND`. The machine has these transitions:
- *hw-set*: overflow pulse or detected pin edge, `FL_IDLE`/`FL_PEND` → `FL_PEND`.
- *sw-set*: write of 1, `FL_IDLE` → `FL_PEND`.
- *sw-clear*: write of 0, `FL_PEND` → `FL_IDLE`.
- *ack-clear*: acknowledge, `FL_PEND` → `FL_IDLE`.
- *follow*: in level mode the state tracks the inverted synchronised pin every cycle and ignores the other transitions.

A hardware set has priority over a software write or an acknowledge in the same cycle. Each external pin passes through a two-flop synchroniser. The synchroniser resets to 1, the idle level.

Top module: `tmr_xint_ctl`

## Requirements
- R1: After reset, every output is 0 and a read returns 0x00.
- R2: While `rd_en` is 1, `rd_data` shows the register in the same cycle, with bit 7 = timer-1 pending, 6 = timer-1 run, 5 = timer-0 pending, 4 = timer-0 run, 3 = ext-1 pending, 2 = ext-1 mode, 1 = ext-0 pending, 0 = ext-0 mode. While `rd_en` is 0, `rd_data` is 0x00.
- R3: A write loads bits 6 and 4 into `tmr_run[1]` and `tmr_run[0]`, visible after the write's clock edge.
- R4: A `tmr_ovf[n]` pulse sets `tmr_pend[n]` at the next clock edge.
- R5: A `tmr_ack[n]` pulse, with no overflow and no write in the same cycle, clears `tmr_pend[n]` at the next clock edge.
- R6: A hardware set event (overflow, or a falling edge in edge mode) in the same cycle as a write of 0 or an acknowledge leaves the flag at 1.
- R7: A write of 1 to a timer pending bit, or to an ext pending bit in edge mode, sets that flag. A write of 0 clears it.
- R8: A change on `xint_n[n]` in level mode appears, inverted, on `xint_pend[n]` after the third clock edge that samples it.
- R9: In edge mode (mode bit = 1), a 1→0 transition on `xint_n[n]` sets `xint_pend[n]` after the third clock edge. A 0→1 transition does not change the flag.
- R10: In edge mode, `xint_ack[n]` clears `xint_pend[n]` at the next edge when no edge is detected in that cycle.
- R11: In level mode (mode bit = 0), `xint_ack[n]` and software writes have no effect on `xint_pend[n]`. The flag equals the inverted synchronised pin.
- R12: A write loads bits 2 and 0 as the ext-1 and ext-0 mode bits. The new mode governs the flag from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 8 | Read data, combinational |
| tmr_ovf | input | 2 | Timer overflow pulses |
| tmr_ack | input | 2 | Timer interrupt vector acknowledge |
| xint_n | input | 2 | External interrupt pins, active low, asynchronous |
| xint_ack | input | 2 | External interrupt vector acknowledge |
| tmr_run | output | 2 | Timer run enables |
| tmr_pend | output | 2 | Timer overflow pending flags |
| xint_pend | output | 2 | External interrupt pending flags |

## Verification
The assertions assume that overflow and acknowledge inputs are single-cycle pulses and that all inputs are stable around the rising edge. They also assume that the pins change at most once between sampling edges. The bench drives every input, including the pins, just after the falling clock edge, so each change is seen at exactly one rising edge and the three-edge pin latency is exact. Coincident events are placed deliberately: an overflow with an acknowledge and a write of 0, a pin edge with an acknowledge, and a mode change with a pending flag. A pseudo-random phase then mixes all inputs while keeping to single-cycle strobes.

// File: rtl/tmr_xint_pkg.sv
package tmr_xint_pkg;
    localparam int NCH = 2;
    localparam int REG_W = 8;

    typedef enum logic {
        FL_IDLE = 1'b0,
        FL_PEND = 1'b1
    } flag_st_t;

    // Bit positions are fixed by the software view of the byte.
    function automatic int pos_tpend(input int n);
        return 5 + 2 * n;
    endfunction
    function automatic int pos_trun(input int n);
        return 4 + 2 * n;
    endfunction
    function automatic int pos_xpend(input int n);
        return 1 + 2 * n;
    endfunction
    function automatic int pos_xmode(input int n);
        return 2 * n;
    endfunction
endpackage

// File: rtl/tmr_xint_sync.sv
module tmr_xint_sync #(
    parameter int  STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic sync_o,
    output logic fall_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;
    logic          prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
            prev_q  <= RST_VAL;
        end else begin
            chain_q <= {chain_q[LAST-1:0], pin_i};
            prev_q  <= chain_q[LAST];
        end
    end

    assign sync_o = chain_q[LAST];
    assign fall_o = prev_q & ~chain_q[LAST];
endmodule

// File: rtl/tmr_xint_flag.sv
module tmr_xint_flag
    import tmr_xint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic follow_en,
    input  logic follow_val,
    input  logic hw_set,
    input  logic sw_wr,
    input  logic sw_val,
    input  logic ack,
    output logic pend
);
    flag_st_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (follow_en) begin
            state_d = follow_val ? FL_PEND : FL_IDLE;
        end else begin
            unique case (state_q)
                FL_IDLE: begin
                    if (hw_set)                state_d = FL_PEND;
                    else if (sw_wr && sw_val)  state_d = FL_PEND;
                end
                FL_PEND: begin
                    if (hw_set)                state_d = FL_PEND;
                    else if (sw_wr)            state_d = sw_val ? FL_PEND : FL_IDLE;
                    else if (ack)              state_d = FL_IDLE;
                end
                default:                       state_d = FL_IDLE;
            endcase
        end
    end

    always_comb begin
        pend = (state_q == FL_PEND);
    end

    p_hw_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set && !follow_en) |=> pend);

    // Also guards R10 for the external channels.
    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !hw_set && !sw_wr && !follow_en) |=> !pend);

    p_follow_pin_r11: assert property (@(posedge clk) disable iff (!rst_n)
        follow_en |=> (pend == $past(follow_val)));
endmodule

// File: rtl/tmr_xint_ctl.sv
module tmr_xint_ctl
    import tmr_xint_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_en,
    output logic [REG_W-1:0] rd_data,
    input  logic [NCH-1:0]   tmr_ovf,
    input  logic [NCH-1:0]   tmr_ack,
    input  logic [NCH-1:0]   xint_n,
    input  logic [NCH-1:0]   xint_ack,
    output logic [NCH-1:0]   tmr_run,
    output logic [NCH-1:0]   tmr_pend,
    output logic [NCH-1:0]   xint_pend
);
    logic [NCH-1:0] run_q;
    logic [NCH-1:0] mode_q;
    logic [NCH-1:0] pin_s;
    logic [NCH-1:0] pin_fall;
    logic [REG_W-1:0] view;

    genvar n;
    generate
        for (n = 0; n < NCH; n++) begin : g_ch
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    run_q[n]  <= 1'b0;
                    mode_q[n] <= 1'b0;
                end else if (wr_en) begin
                    run_q[n]  <= wr_data[pos_trun(n)];
                    mode_q[n] <= wr_data[pos_xmode(n)];
                end
            end

            tmr_xint_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
                .clk    (clk),
                .rst_n  (rst_n),
                .pin_i  (xint_n[n]),
                .sync_o (pin_s[n]),
                .fall_o (pin_fall[n])
            );

            tmr_xint_flag u_tflag (
                .clk        (clk),
                .rst_n      (rst_n),
                .follow_en  (1'b0),
                .follow_val (1'b0),
                .hw_set     (tmr_ovf[n]),
                .sw_wr      (wr_en),
                .sw_val     (wr_data[pos_tpend(n)]),
                .ack        (tmr_ack[n]),
                .pend       (tmr_pend[n])
            );

            tmr_xint_flag u_xflag (
                .clk        (clk),
                .rst_n      (rst_n),
                .follow_en  (~mode_q[n]),
                .follow_val (~pin_s[n]),
                .hw_set     (pin_fall[n]),
                .sw_wr      (wr_en),
                .sw_val     (wr_data[pos_xpend(n)]),
                .ack        (xint_ack[n]),
                .pend       (xint_pend[n])
            );

            always_comb begin
                view[pos_tpend(n)] = tmr_pend[n];
                view[pos_trun(n)]  = run_q[n];
                view[pos_xpend(n)] = xint_pend[n];
                view[pos_xmode(n)] = mode_q[n];
            end

            p_run_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en |=> (tmr_run[n] == $past(wr_data[pos_trun(n)])));

            p_mode_load_r12: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en |=> (mode_q[n] == $past(wr_data[pos_xmode(n)])));

            p_fall_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_q[n] && pin_fall[n]) |=> xint_pend[n]);
        end
    endgenerate

    assign tmr_run = run_q;
    assign rd_data = rd_en ? view : '0;
endmodule

// File: tb/sim_tmr_xint_ctl.sv
`timescale 1ns/1ps
module sim_tmr_xint_ctl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [1:0] tmr_ovf = '0, tmr_ack = '0, xint_n = 2'b11, xint_ack = '0;
    logic [1:0] tmr_run, tmr_pend, xint_pend;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    bit m_tf[2], m_tr[2], m_ie[2], m_it[2], s1[2], s2[2], s3[2];

    always #2.5 clk = ~clk;

    tmr_xint_ctl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .tmr_ovf(tmr_ovf), .tmr_ack(tmr_ack),
        .xint_n(xint_n), .xint_ack(xint_ack), .tmr_run(tmr_run),
        .tmr_pend(tmr_pend), .xint_pend(xint_pend)
    );

    function automatic logic [7:0] m_byte();
        return {m_tf[1], m_tr[1], m_tf[0], m_tr[0], m_ie[1], m_it[1], m_ie[0], m_it[0]};
    endfunction

    task automatic model_edge();
        for (int c = 0; c < 2; c++) begin
            bit edge_seen = s3[c] && !s2[c];
            if (!rst_n) begin
                m_tf[c] = 0; m_tr[c] = 0; m_ie[c] = 0; m_it[c] = 0;
                s1[c] = 1; s2[c] = 1; s3[c] = 1;
            end else begin
                if (!m_it[c])               m_ie[c] = !s2[c];
                else if (edge_seen)         m_ie[c] = 1;
                else if (wr_en)             m_ie[c] = wr_data[1 + 2*c];
                else if (xint_ack[c])       m_ie[c] = 0;
                if (tmr_ovf[c])             m_tf[c] = 1;
                else if (wr_en)             m_tf[c] = wr_data[5 + 2*c];
                else if (tmr_ack[c])        m_tf[c] = 0;
                if (wr_en) begin
                    m_tr[c] = wr_data[4 + 2*c];
                    m_it[c] = wr_data[2*c];
                end
                s3[c] = s2[c]; s2[c] = s1[c]; s1[c] = xint_n[c];
            end
        end
    endtask

    task automatic compare();
        logic [7:0] exp_b = m_byte();
        logic [7:0] exp_rd = rd_en ? exp_b : 8'h00;
        logic [5:0] act = {tmr_run, tmr_pend, xint_pend};
        logic [5:0] exp_o = {exp_b[6], exp_b[4], exp_b[7], exp_b[5], exp_b[3], exp_b[1]};
        n_chk++;
        if (act !== exp_o || rd_data !== exp_rd) begin
            n_bad++;
            $display("FAIL %s t=%0t outputs=%b rd=%h expected outputs=%b rd=%h",
                     cur_req, $time, act, rd_data, exp_o, exp_rd);
        end
    endtask

    // One clock: inputs are already set; model follows the edge, then compare.
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
        wr_en = 0; tmr_ovf = '0; tmr_ack = '0; xint_ack = '0;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) step();
    endtask

    task automatic write(input logic [7:0] d);
        wr_en = 1; wr_data = d; step();
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        @(negedge clk);
        rd_en = 1;
        cur_req = "R1"; idle(3);
        rst_n = 1;
        idle(2);

        cur_req = "R2"; rd_en = 0; idle(1); rd_en = 1;
        cur_req = "R3"; write(8'h50); idle(1); write(8'h10); idle(1);

        cur_req = "R4"; tmr_ovf = 2'b01; step(); tmr_ovf = 2'b10; step();
        cur_req = "R5"; tmr_ack = 2'b01; step(); idle(1);
        cur_req = "R6"; tmr_ovf = 2'b10; tmr_ack = 2'b10; wr_en = 1; wr_data = 8'h00; step();
        cur_req = "R5"; tmr_ack = 2'b10; step();
        cur_req = "R7"; write(8'hA0); write(8'h20); write(8'h00);

        cur_req = "R8"; xint_n = 2'b10; idle(4); xint_n = 2'b11; idle(4);
        cur_req = "R11"; xint_n = 2'b01; idle(3);
        xint_ack = 2'b10; step(); write(8'h00); idle(2);
        xint_n = 2'b11; idle(4);

        cur_req = "R12"; write(8'h05); idle(1);
        cur_req = "R7"; write(8'h0F); write(8'h05);
        cur_req = "R9"; xint_n = 2'b10; idle(4); xint_n = 2'b11; idle(4);
        cur_req = "R10"; xint_ack = 2'b01; step(); idle(1);
        cur_req = "R9"; xint_n = 2'b01; idle(4);
        cur_req = "R10"; xint_ack = 2'b10; step();
        xint_n = 2'b11; idle(3);
        cur_req = "R6"; xint_n = 2'b10; idle(2); xint_ack = 2'b01; wr_en = 1; wr_data = 8'h05; step();
        idle(2); xint_n = 2'b11; idle(3);
        cur_req = "R12"; xint_n = 2'b00; idle(3); write(8'h00); idle(3); xint_n = 2'b11; idle(4);

        cur_req = "R2";
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            wr_en = (lfsr[3:0] == 4'h0);
            wr_data = lfsr[15:8];
            rd_en = lfsr[4];
            tmr_ovf = lfsr[6:5] & {2{lfsr[7]}};
            tmr_ack = lfsr[9:8] & {2{lfsr[10]}};
            xint_ack = lfsr[12:11];
            if (lfsr[2:0] == 3'd5) xint_n = lfsr[14:13];
            step();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule